// File: doc/BRIEF.md
# Dual-Clock Line Store-and-Forward Buffer

This block connects a slow pixel source to a fast serial video transmitter. The transmitter cannot send a gap inside a line, because its link has no filler word. The source pushes 16-bit 4:2:2 pixels, one per beat, through a valid-qualified stream in the write clock domain. A start-of-frame marker rides on the first beat of a line and an end-of-line marker on its last beat. The block holds each line until every pixel of it has arrived. It then releases the line in the faster read clock domain as a single unbroken burst.

Two line memories alternate. The writer fills one while the reader drains the other. Ownership of each memory passes between the domains through single-bit toggles, each synchronised with two flops, so no counter or pointer crosses a clock boundary. Three sticky error flags cover the failure modes. Overrun means a line was dropped for lack of a free memory. Length error means a line ended at the wrong pixel count. Stall means the receiver deasserted ready while a burst was in progress. Each flag is cleared by a synchronous clear input in its own domain.

The read clock has to be fast enough that the transmitter is never starved. As a sizing rule, the read clock frequency × 16 bits × pixels per beat must exceed the transmitter byte clock × lane count × 8.

Top module: `lsf_line_buffer`

## Requirements
- R1: A line becomes available to the reader only after its end-of-line beat has been accepted at exactly pixel LINE_LEN. Every such committed line is delivered on the output exactly once.
- R2: Once out_valid rises, it stays high for LINE_LEN consecutive read cycles whatever out_ready does. out_eol is high on the LINE_LEN-th pixel and on no other pixel. A following line may start on the next cycle.
- R3: Pixels leave in the order they were written. Lines leave in the order they were committed, with the writer and the reader both alternating between the two memories starting from memory 0.
- R4: If a line's first beat arrives while the memory the writer needs has not yet been released by the reader, the whole line is discarded and overrun_err is set. The flag stays set until wr_clr.
- R5: A kept line whose end-of-line beat comes at a pixel count other than LINE_LEN is discarded and sets length_err, which stays set until wr_clr. Pixels beyond LINE_LEN are not stored.
- R6: in_sof counts only on the first beat of a line. The first committed line that starts with or after such a marker, including when the marked line itself was dropped, carries out_sof on its first output pixel. No other pixel carries out_sof.
- R7: A read cycle with out_valid high and out_ready low sets stall_err, which stays set until rd_clr. The burst continues regardless.
- R8: After reset, out_valid, out_sof, out_eol, overrun_err, length_err and stall_err are low. in_ready is high from the second write clock edge after the write reset is released.
- R9: wr_clr clears overrun_err and length_err and wins over a set in the same cycle. rd_clr does the same for stall_err. Neither clear affects the flags of the other domain.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wr_clk | input | 1 | Write-domain clock (pixel source) |
| wr_arst_n | input | 1 | Write-domain asynchronous active-low reset |
| wr_clr | input | 1 | Synchronous clear of overrun_err and length_err |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input ready; high whenever the write domain is out of reset |
| in_data | input | PIX_W | Input pixel |
| in_sof | input | 1 | Start-of-frame marker, meaningful on a line's first beat |
| in_eol | input | 1 | End-of-line marker on a line's last beat |
| overrun_err | output | 1 | Sticky: a line was dropped because no memory was free |
| length_err | output | 1 | Sticky: a line ended at the wrong pixel count |
| rd_clk | input | 1 | Read-domain clock (transmitter side) |
| rd_arst_n | input | 1 | Read-domain asynchronous active-low reset |
| rd_clr | input | 1 | Synchronous clear of stall_err |
| out_valid | output | 1 | Output beat valid; held through a whole line |
| out_ready | input | 1 | Receiver ready; sampled only for the stall flag |
| out_data | output | PIX_W | Output pixel |
| out_sof | output | 1 | First pixel of the first line of a frame |
| out_eol | output | 1 | Last pixel of a line |
| stall_err | output | 1 | Sticky: out_ready was low during a burst |

## Verification
The hardest case to reach is the overrun. The read clock is far faster than the write clock, so the reader always frees a memory long before the writer needs it. The bench therefore stops the read clock between lines, writes two full lines and then two more. The third and fourth lines must be dropped. The third carries a start-of-frame marker, so once the read clock runs again the bench can check that the marker moves on to the next line that is kept. Short and long lines, a start-of-frame marker in mid-line, and a ready drop in mid-burst are driven through the same behavioural model, which is compared with the outputs on every clock of both domains.

// File: rtl/lsf_pkg.sv
package lsf_pkg;

  // Number of line memories; the ping-pong scheme relies on exactly two.
  localparam int unsigned NUM_BUF = 2;

  typedef enum logic {
    WM_FILL = 1'b0,   // storing, or waiting for a line's first beat
    WM_DROP = 1'b1    // discarding the rest of a refused line
  } wr_mode_e;

  typedef enum logic {
    RM_IDLE  = 1'b0,
    RM_BURST = 1'b1
  } rd_mode_e;

endpackage

// File: rtl/lsf_rst_sync.sv
module lsf_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= 2'b00;
    end else begin
      sh_q <= {sh_q[0], 1'b1};
    end
  end

  assign rst_n = sh_q[1];

endmodule

// File: rtl/lsf_bit_sync.sv
module lsf_bit_sync #(
  parameter int unsigned WIDTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d;
      sync_q <= meta_q;
    end
  end

  assign q = sync_q;

endmodule

// File: rtl/lsf_line_ram.sv
module lsf_line_ram #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 1280,
  parameter int unsigned ADDR_W = 11
) (
  input  logic              wr_clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_clk,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge wr_clk) begin
    if (wr_en) begin
      mem_q[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge rd_clk) begin
    if (rd_en) begin
      rd_data <= mem_q[rd_addr];
    end
  end

endmodule

// File: rtl/lsf_wr_ctrl.sv
module lsf_wr_ctrl
  import lsf_pkg::*;
#(
  parameter int unsigned PIX_W    = 16,
  parameter int unsigned LINE_LEN = 1280,
  parameter int unsigned ADDR_W   = 11,
  parameter int unsigned CNT_W    = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              in_valid,
  input  logic [PIX_W-1:0]  in_data,
  input  logic              in_sof,
  input  logic              in_eol,
  input  logic [1:0]        done_sync,
  output logic [1:0]        fill_tgl,
  output logic [1:0]        sof_mark,
  output logic [1:0]        ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [PIX_W-1:0]  ram_data,
  output logic              overrun_err,
  output logic              length_err
);

  localparam logic [CNT_W-1:0] LEN_C  = CNT_W'(LINE_LEN);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(LINE_LEN - 1);
  localparam logic [CNT_W-1:0] ONE_C  = CNT_W'(1);

  wr_mode_e         mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             sel_q, sel_d;
  logic [1:0]       fill_q, fill_d;
  logic [1:0]       sofm_q, sofm_d;
  logic             pend_q, pend_d;
  logic             ovr_q, ovr_d;
  logic             len_q, len_d;

  logic [1:0] full_w;
  logic       first_beat, line_drop, keep, room, at_last;
  logic       commit, bad_len, sof_now, we, upd;

  // A memory is owned by the reader while its fill and done toggles differ.
  assign full_w     = fill_q ^ done_sync;
  assign first_beat = (mode_q == WM_FILL) && (cnt_q == '0);
  assign line_drop  = in_valid && first_beat && full_w[sel_q];
  assign keep       = in_valid && (mode_q == WM_FILL) && !line_drop;
  assign room       = (cnt_q < LEN_C);
  assign at_last    = (cnt_q == LAST_C);
  assign we         = keep && room;
  assign commit     = keep && in_eol && at_last;
  assign bad_len    = keep && in_eol && !at_last;
  assign sof_now    = in_valid && first_beat && in_sof;
  assign upd        = in_valid || clr;

  always_comb begin
    mode_d = mode_q;
    cnt_d  = cnt_q;
    sel_d  = sel_q;
    fill_d = fill_q;
    sofm_d = sofm_q;
    pend_d = pend_q;

    if (in_valid) begin
      if (line_drop) begin
        mode_d = in_eol ? WM_FILL : WM_DROP;
      end else if (mode_q == WM_DROP) begin
        if (in_eol) begin
          mode_d = WM_FILL;
        end
      end else if (in_eol) begin
        cnt_d = '0;
      end else if (room) begin
        cnt_d = cnt_q + ONE_C;
      end
    end

    if (sof_now) begin
      pend_d = 1'b1;
    end

    if (commit) begin
      fill_d[sel_q] = ~fill_q[sel_q];
      sofm_d[sel_q] = pend_q || sof_now;
      sel_d         = ~sel_q;
      pend_d        = 1'b0;
    end

    ovr_d = clr ? 1'b0 : (ovr_q || line_drop);
    len_d = clr ? 1'b0 : (len_q || bad_len);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= WM_FILL;
      cnt_q  <= '0;
      sel_q  <= 1'b0;
      fill_q <= 2'b00;
      sofm_q <= 2'b00;
      pend_q <= 1'b0;
      ovr_q  <= 1'b0;
      len_q  <= 1'b0;
    end else if (upd) begin
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      sel_q  <= sel_d;
      fill_q <= fill_d;
      sofm_q <= sofm_d;
      pend_q <= pend_d;
      ovr_q  <= ovr_d;
      len_q  <= len_d;
    end
  end

  assign ram_we[0]   = we && !sel_q;
  assign ram_we[1]   = we &&  sel_q;
  assign ram_addr    = cnt_q[ADDR_W-1:0];
  assign ram_data    = in_data;
  assign fill_tgl    = fill_q;
  assign sof_mark    = sofm_q;
  assign overrun_err = ovr_q;
  assign length_err  = len_q;

  // R4
  no_write_owned_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|ram_we) |-> !full_w[sel_q]);

  // R4
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q && !clr |=> ovr_q);

  // R5
  length_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    len_q && !clr |=> len_q);

  // R1
  commit_on_eol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(fill_q) |-> $past(in_valid && in_eol));

endmodule

// File: rtl/lsf_rd_ctrl.sv
module lsf_rd_ctrl
  import lsf_pkg::*;
#(
  parameter int unsigned PIX_W    = 16,
  parameter int unsigned LINE_LEN = 1280,
  parameter int unsigned ADDR_W   = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic [1:0]           fill_sync,
  input  logic [1:0]           sof_mark,
  output logic [1:0]           done_tgl,
  output logic [1:0]           ram_re,
  output logic [ADDR_W-1:0]    ram_addr,
  input  logic [1:0][PIX_W-1:0] ram_q,
  input  logic                 out_ready,
  output logic                 out_valid,
  output logic [PIX_W-1:0]     out_data,
  output logic                 out_sof,
  output logic                 out_eol,
  output logic                 stall_err
);

  localparam logic [ADDR_W-1:0] LAST_A = ADDR_W'(LINE_LEN - 1);
  localparam logic [ADDR_W-1:0] ONE_A  = ADDR_W'(1);

  rd_mode_e          mode_q, mode_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic              sel_q, sel_d;
  logic [1:0]        done_q, done_d;
  logic              vld_q, vld_d;
  logic              eol_q, eol_d;
  logic              sof_q, sof_d;
  logic              bsel_q;
  logic              stall_q, stall_d;

  logic [1:0] avail;
  logic       start, issue, last;

  assign avail = fill_sync ^ done_q;
  assign start = (mode_q == RM_IDLE) && avail[sel_q];
  assign issue = start || (mode_q == RM_BURST);
  assign last  = (addr_q == LAST_A);

  always_comb begin
    mode_d = mode_q;
    addr_d = addr_q;
    sel_d  = sel_q;
    done_d = done_q;
    if (issue) begin
      if (last) begin
        addr_d        = '0;
        mode_d        = RM_IDLE;
        done_d[sel_q] = ~done_q[sel_q];
        sel_d         = ~sel_q;
      end else begin
        addr_d = addr_q + ONE_A;
        mode_d = RM_BURST;
      end
    end
    vld_d   = issue;
    eol_d   = issue && last;
    sof_d   = issue && (addr_q == '0) && sof_mark[sel_q];
    stall_d = clr ? 1'b0 : (stall_q || (vld_q && !out_ready));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= RM_IDLE;
      addr_q <= '0;
      sel_q  <= 1'b0;
      done_q <= 2'b00;
    end else if (issue) begin
      mode_q <= mode_d;
      addr_q <= addr_d;
      sel_q  <= sel_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= 1'b0;
      eol_q   <= 1'b0;
      sof_q   <= 1'b0;
      bsel_q  <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      eol_q   <= eol_d;
      sof_q   <= sof_d;
      stall_q <= stall_d;
      if (issue) begin
        bsel_q <= sel_q;
      end
    end
  end

  assign ram_re[0] = issue && !sel_q;
  assign ram_re[1] = issue &&  sel_q;
  assign ram_addr  = addr_q;
  assign done_tgl  = done_q;
  assign out_valid = vld_q;
  assign out_eol   = eol_q;
  assign out_sof   = sof_q;
  assign out_data  = ram_q[bsel_q];
  assign stall_err = stall_q;

  // R2
  burst_gapless_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_eol |=> out_valid);

  // R2
  eol_inside_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_eol |-> out_valid);

  // R6
  sof_leads_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_sof |-> ($past(out_eol) || !$past(out_valid)));

  // R7
  stall_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q && !clr |=> stall_q);

endmodule

// File: rtl/lsf_line_buffer.sv
module lsf_line_buffer
  import lsf_pkg::*;
#(
  parameter int unsigned PIX_W    = 16,
  parameter int unsigned LINE_LEN = 1280
) (
  input  logic             wr_clk,
  input  logic             wr_arst_n,
  input  logic             wr_clr,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [PIX_W-1:0] in_data,
  input  logic             in_sof,
  input  logic             in_eol,
  output logic             overrun_err,
  output logic             length_err,
  input  logic             rd_clk,
  input  logic             rd_arst_n,
  input  logic             rd_clr,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [PIX_W-1:0] out_data,
  output logic             out_sof,
  output logic             out_eol,
  output logic             stall_err
);

  localparam int unsigned ADDR_W = (LINE_LEN > 1) ? $clog2(LINE_LEN) : 1;
  localparam int unsigned CNT_W  = $clog2(LINE_LEN + 1);

  logic wr_rst_n, rd_rst_n;

  logic [1:0]              fill_tgl, fill_sync;
  logic [1:0]              done_tgl, done_sync;
  logic [1:0]              sof_mark;
  logic [1:0]              ram_we, ram_re;
  logic [ADDR_W-1:0]       wr_addr, rd_addr;
  logic [PIX_W-1:0]        wr_data;
  logic [1:0][PIX_W-1:0]   ram_q;

  lsf_rst_sync u_wr_rst (.clk(wr_clk), .arst_n(wr_arst_n), .rst_n(wr_rst_n));
  lsf_rst_sync u_rd_rst (.clk(rd_clk), .arst_n(rd_arst_n), .rst_n(rd_rst_n));

  assign in_ready = wr_rst_n;

  lsf_bit_sync #(.WIDTH(NUM_BUF)) u_fill_to_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .d(fill_tgl), .q(fill_sync)
  );

  lsf_bit_sync #(.WIDTH(NUM_BUF)) u_done_to_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .d(done_tgl), .q(done_sync)
  );

  lsf_wr_ctrl #(
    .PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_wr (
    .clk(wr_clk), .rst_n(wr_rst_n), .clr(wr_clr),
    .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eol(in_eol),
    .done_sync(done_sync), .fill_tgl(fill_tgl), .sof_mark(sof_mark),
    .ram_we(ram_we), .ram_addr(wr_addr), .ram_data(wr_data),
    .overrun_err(overrun_err), .length_err(length_err)
  );

  lsf_rd_ctrl #(
    .PIX_W(PIX_W), .LINE_LEN(LINE_LEN), .ADDR_W(ADDR_W)
  ) u_rd (
    .clk(rd_clk), .rst_n(rd_rst_n), .clr(rd_clr),
    .fill_sync(fill_sync), .sof_mark(sof_mark), .done_tgl(done_tgl),
    .ram_re(ram_re), .ram_addr(rd_addr), .ram_q(ram_q),
    .out_ready(out_ready), .out_valid(out_valid), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .stall_err(stall_err)
  );

  for (genvar b = 0; b < NUM_BUF; b++) begin : g_mem
    lsf_line_ram #(
      .DATA_W(PIX_W), .DEPTH(LINE_LEN), .ADDR_W(ADDR_W)
    ) u_ram (
      .wr_clk(wr_clk), .wr_en(ram_we[b]), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_clk(rd_clk), .rd_en(ram_re[b]), .rd_addr(rd_addr), .rd_data(ram_q[b])
    );
  end

endmodule

// File: tb/test_lsf_line_buffer.sv
module test_lsf_line_buffer;

  localparam int LINE = 8;
  localparam int PIX  = 16;

  logic wr_clk = 1'b0;
  logic rd_clk = 1'b0;
  bit   rd_run = 1'b1;

  logic            wr_arst_n = 1'b0, rd_arst_n = 1'b0;
  logic            wr_clr = 1'b0, rd_clr = 1'b0;
  logic            in_valid = 1'b0, in_sof = 1'b0, in_eol = 1'b0;
  logic [PIX-1:0]  in_data = '0;
  logic            out_ready = 1'b1;
  logic            in_ready, overrun_err, length_err;
  logic            out_valid, out_sof, out_eol, stall_err;
  logic [PIX-1:0]  out_data;

  always #10 wr_clk = ~wr_clk;
  always begin
    #4;
    if (rd_run) rd_clk = ~rd_clk;
  end

  lsf_line_buffer #(.PIX_W(PIX), .LINE_LEN(LINE)) i_lsf_line_buffer (
    .wr_clk(wr_clk), .wr_arst_n(wr_arst_n), .wr_clr(wr_clr),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .in_sof(in_sof), .in_eol(in_eol),
    .overrun_err(overrun_err), .length_err(length_err),
    .rd_clk(rd_clk), .rd_arst_n(rd_arst_n), .rd_clr(rd_clr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_sof(out_sof), .out_eol(out_eol), .stall_err(stall_err)
  );

  int n_chk = 0, n_fail = 0;
  bit live = 1'b0;
  bit done_flag = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [PIX-1:0] exp_pix[$];
  bit             exp_sof[$];
  logic [PIX-1:0] cur [LINE];
  int  m_cnt = 0, m_committed = 0, m_done = 0, m_idx = 0;
  bit  m_drop = 0, m_pend = 0, m_ovr = 0, m_len = 0, m_stall = 0;
  bit  w_first, w_oset, w_lset;
  int  w_infl;
  logic [PIX-1:0] w_exp;

  always @(posedge wr_clk) if (live) begin
    w_oset = 0;
    w_lset = 0;
    if (in_valid) begin
      w_first = (m_cnt == 0) && !m_drop;
      w_infl  = m_committed - m_done;
      if (w_first && in_sof) m_pend = 1;
      if (w_first && w_infl >= 2) begin
        w_oset = 1;
        m_drop = !in_eol;
      end else if (m_drop) begin
        if (in_eol) m_drop = 0;
      end else begin
        if (m_cnt < LINE) cur[m_cnt] = in_data;
        if (in_eol) begin
          if (m_cnt == LINE - 1) begin
            for (int i = 0; i < LINE; i++) exp_pix.push_back(cur[i]);
            exp_sof.push_back(m_pend);
            m_pend = 0;
            m_committed++;
          end else begin
            w_lset = 1;
          end
          m_cnt = 0;
        end else if (m_cnt < LINE) begin
          m_cnt++;
        end
      end
    end
    m_ovr = wr_clr ? 1'b0 : (m_ovr | w_oset);
    m_len = wr_clr ? 1'b0 : (m_len | w_lset);
  end

  always @(negedge wr_clk) if (live) begin
    check(overrun_err == m_ovr, "R4", "overrun_err", overrun_err, m_ovr);
    check(length_err == m_len, "R5", "length_err", length_err, m_len);
    check(in_ready == 1'b1, "R8", "in_ready", in_ready, 1);
  end

  always @(negedge rd_clk) if (live) begin
    if (m_idx > 0) check(out_valid == 1'b1, "R2", "out_valid mid-line", out_valid, 1);
    if (out_valid) begin
      if (m_idx == 0)
        check(exp_pix.size() >= LINE, "R1", "line released before committed",
              exp_pix.size(), LINE);
      if (exp_pix.size() > 0) begin
        w_exp = exp_pix.pop_front();
        check(out_data == w_exp, "R3", "out_data", out_data, w_exp);
      end
      if (m_idx == 0 && exp_sof.size() > 0)
        check(out_sof == exp_sof[0], "R6", "out_sof first pixel", out_sof, exp_sof[0]);
      else
        check(out_sof == 1'b0, "R6", "out_sof later pixel", out_sof, 0);
      check(out_eol == (m_idx == LINE - 1), "R2", "out_eol", out_eol, m_idx == LINE - 1);
      if (m_idx == LINE - 1) begin
        m_idx = 0;
        if (exp_sof.size() > 0) void'(exp_sof.pop_front());
        m_done++;
      end else begin
        m_idx++;
      end
    end else begin
      check(out_eol == 1'b0 && out_sof == 1'b0, "R2", "markers while idle",
            {out_eol, out_sof}, 0);
    end
    check(stall_err == m_stall, "R7", "stall_err", stall_err, m_stall);
    m_stall = rd_clr ? 1'b0 : (m_stall | (out_valid && !out_ready));
  end

  // ---------------- stimulus ----------------
  logic [PIX-1:0] seed = 16'h1234;

  task automatic send_line(input int n, input bit sof_first, input bit sof_mid,
                           input int gap);
    for (int i = 0; i < n; i++) begin
      @(posedge wr_clk); #2;
      seed     = seed * 16'd25173 + 16'd13849;
      in_valid = 1'b1;
      in_data  = seed;
      in_sof   = (i == 0 && sof_first) || (i == 2 && sof_mid);
      in_eol   = (i == n - 1);
    end
    @(posedge wr_clk); #2;
    in_valid = 1'b0;
    in_sof   = 1'b0;
    in_eol   = 1'b0;
    repeat (gap) @(posedge wr_clk);
  endtask

  task automatic drain();
    while (exp_pix.size() != 0 || m_idx != 0) @(posedge wr_clk);
    repeat (6) @(posedge wr_clk);
  endtask

  task automatic pulse_wr_clr();
    @(posedge wr_clk); #2 wr_clr = 1'b1;
    @(posedge wr_clk); #2 wr_clr = 1'b0;
    @(negedge wr_clk);
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!done_flag) begin
      check(1'b0, "R1", "watchdog expired", 0, 1);
      finish_run();
    end
  end

  initial begin
    repeat (4) @(posedge wr_clk);
    #2 wr_arst_n = 1'b1;
    rd_arst_n = 1'b1;
    repeat (4) @(posedge wr_clk);
    @(negedge wr_clk);
    // R8 reset state
    check(out_valid == 1'b0, "R8", "out_valid after reset", out_valid, 0);
    check(out_sof == 1'b0 && out_eol == 1'b0, "R8", "markers after reset",
          {out_sof, out_eol}, 0);
    check(overrun_err == 1'b0, "R8", "overrun_err after reset", overrun_err, 0);
    check(length_err == 1'b0, "R8", "length_err after reset", length_err, 0);
    check(stall_err == 1'b0, "R8", "stall_err after reset", stall_err, 0);
    check(in_ready == 1'b1, "R8", "in_ready after reset", in_ready, 1);
    live = 1'b1;

    // R1 R3 R6: spaced lines, frame start on the first
    send_line(LINE, 1, 0, 5);
    send_line(LINE, 0, 1, 5);   // mid-line marker is ignored
    send_line(LINE, 0, 0, 5);
    drain();

    // R2 R3: back-to-back lines, frame start on the second
    send_line(LINE, 0, 0, 0);
    send_line(LINE, 1, 0, 0);
    send_line(LINE, 0, 0, 0);
    send_line(LINE, 0, 0, 0);
    drain();

    // R5: short line, long line, then a good one
    send_line(LINE - 3, 0, 0, 3);
    check(length_err == 1'b1, "R5", "short line flagged", length_err, 1);
    send_line(LINE + 3, 0, 0, 3);
    send_line(LINE, 0, 0, 3);
    drain();
    pulse_wr_clr();
    check(length_err == 1'b0, "R9", "wr_clr clears length_err", length_err, 0);

    // R7: ready drops in mid-burst
    send_line(LINE, 0, 0, 0);
    while (!out_valid) @(posedge rd_clk);
    @(posedge rd_clk); #1 out_ready = 1'b0;
    repeat (2) @(posedge rd_clk);
    #1 out_ready = 1'b1;
    drain();
    check(stall_err == 1'b1, "R7", "stall_err set", stall_err, 1);
    check(overrun_err == 1'b0 && length_err == 1'b0, "R9",
          "write flags untouched by stall", {overrun_err, length_err}, 0);
    @(posedge rd_clk); #1 rd_clr = 1'b1;
    @(posedge rd_clk); #1 rd_clr = 1'b0;
    @(negedge rd_clk);
    check(stall_err == 1'b0, "R9", "rd_clr clears stall_err", stall_err, 0);

    // R4 R6: read clock stopped, both memories fill, two lines dropped
    @(negedge rd_clk); rd_run = 1'b0;
    send_line(LINE, 0, 0, 2);
    send_line(LINE, 0, 0, 2);
    send_line(LINE, 1, 0, 2);
    check(overrun_err == 1'b1, "R4", "overrun on third line", overrun_err, 1);
    send_line(LINE, 0, 0, 2);
    @(posedge wr_clk); rd_run = 1'b1;
    drain();
    send_line(LINE, 0, 0, 2);   // inherits the dropped frame start
    drain();
    check(overrun_err == 1'b1, "R4", "overrun stays set", overrun_err, 1);
    pulse_wr_clr();
    check(overrun_err == 1'b0, "R9", "wr_clr clears overrun_err", overrun_err, 0);

    check(exp_pix.size() == 0, "R1", "all committed lines delivered",
          exp_pix.size(), 0);
    check(m_committed == m_done, "R1", "line count delivered", m_done, m_committed);
    done_flag = 1'b1;
    live = 1'b0;
    finish_run();
  end

endmodule